// File: doc/BRIEF.md
# Pipeline Exception Controller

This block watches the execute stage of an in-order pipeline for two synchronous faults (an undefined opcode and an arithmetic overflow) and also watches an external interrupt request. When it accepts an event it records a return address and a cause code. It then raises one-cycle strobes that kill the instruction in execute and everything fetched behind it, and that stop the faulting instruction from writing its destination register. In the same cycle it hands the fetch unit a new PC to start the handler from.

A mode input picks the handler entry. In fixed mode every event goes to one common entry. In vectored mode each cause has its own slot, and the slots are 0x20 bytes apart. While a handler is running, further events are masked. A return pulse from the handler sends fetch back to the saved address and re-arms the controller. The saved address and the cause are readable through two read ports.

All outputs are registered. An event sampled at one rising edge shows its effects on the outputs in the cycle that follows that edge.

Top module: `exc_unit`

## Requirements
- R1: During and after reset, with no event, all strobes are low, and the saved address and cause code both read zero.
- R2: An undefined-opcode flag that is accepted sets cause code 2'b00 and saves the execute PC plus 4. In the next cycle it raises flushEx, flushFront, wbSuppress and redirectValid.
- R3: An overflow flag that is accepted sets cause code 2'b01 and saves the execute PC plus 4. It raises the same four strobes as R2, including wbSuppress.
- R4: When both fault flags are set in the same cycle, the undefined-opcode cause (2'b00) wins.
- R5: With vecMode low, redirectPc on acceptance is 0x8000_0180 for every cause.
- R6: With vecMode high, redirectPc on acceptance is 0xC000_0000 for undefined opcode, 0xC000_0020 for overflow and 0xC000_0040 for an interrupt.
- R7: An interrupt is accepted only when neither fault flag is set. It sets cause code 2'b10, saves the execute PC unchanged, and raises flushEx, flushFront and redirectValid but not wbSuppress.
- R8: While a handler is active, fault flags and interrupt requests are ignored. No strobe rises, and the saved address and cause keep their values.
- R9: A return pulse while a handler is active gives one cycle of redirectValid and flushFront, with redirectPc equal to the saved address and flushEx low. Events are accepted again from the next cycle.
- R10: A return pulse while no handler is active has no effect on any output.
- R11: Every strobe raised for an accepted event is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| exUndef | input | 1 | Instruction in execute has an undefined opcode |
| exOvf | input | 1 | Instruction in execute overflowed |
| exPc | input | 32 | PC of the instruction in execute |
| irqReq | input | 1 | External interrupt request |
| vecMode | input | 1 | 1 selects per-cause entries, 0 selects the common entry |
| eretPulse | input | 1 | Return-from-handler pulse |
| flushFront | output | 1 | Kill the fetch and decode stages |
| flushEx | output | 1 | Kill the instruction leaving execute |
| wbSuppress | output | 1 | Block the register write of the faulting instruction |
| redirectValid | output | 1 | Load redirectPc into the fetch PC |
| redirectPc | output | 32 | New fetch address, meaningful while redirectValid is high |
| epcOut | output | 32 | Saved return address |
| causeOut | output | 2 | Saved cause code |

## Verification
A wrong handler-active state is visible at the ports one cycle later. A controller that is stuck unmasked raises a second flush while a handler runs. A controller that is stuck masked swallows the first event after a return. A wrong priority choice or a wrong captured PC shows up as a wrong causeOut, epcOut or redirectPc in the cycle after acceptance. An eret then redirects to that wrong address. The bench model is compared against every output on every clock, so each such error is reported in the cycle it first appears.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    CAUSE_UNDEF = 2'b00,
    CAUSE_OVF   = 2'b01,
    CAUSE_IRQ   = 2'b10
  } causeE;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;    // event accepted this cycle
    logic  syncFault;  // accepted event is tied to the execute instruction
    causeE code;       // winning cause
    logic  eretTake;   // return accepted this cycle
  } excStrobeT;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      exUndef,
  input  logic      exOvf,
  input  logic      irqReq,
  input  logic      eretPulse,
  output excStrobeT strobe,
  output logic      flushFront,
  output logic      flushEx,
  output logic      wbSuppress,
  output logic      redirectValid
);

  logic  handlerActive;
  logic  anyFault;
  logic  accept;
  logic  eretTake;
  causeE winCode;

  assign anyFault = exUndef | exOvf;
  assign accept   = !handlerActive && (anyFault || irqReq);
  assign eretTake = handlerActive && eretPulse;

  // fixed priority: undefined opcode, then overflow, then interrupt
  always_comb begin
    if (exUndef)    winCode = CAUSE_UNDEF;
    else if (exOvf) winCode = CAUSE_OVF;
    else            winCode = CAUSE_IRQ;
  end

  always_comb begin
    strobe.capture   = accept;
    strobe.syncFault = anyFault;
    strobe.code      = winCode;
    strobe.eretTake  = eretTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      handlerActive <= 1'b0;
      flushFront    <= 1'b0;
      flushEx       <= 1'b0;
      wbSuppress    <= 1'b0;
      redirectValid <= 1'b0;
    end else begin
      if (accept)        handlerActive <= 1'b1;
      else if (eretTake) handlerActive <= 1'b0;
      flushFront    <= accept || eretTake;
      flushEx       <= accept;
      wbSuppress    <= accept && anyFault;
      redirectValid <= accept || eretTake;
    end
  end

  // R11
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushEx |=> !flushEx);

  // R7
  wb_needs_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbSuppress |-> (flushEx && flushFront && redirectValid));

  // R8
  masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handlerActive && !eretPulse) |=> !flushEx && !redirectValid);

  // R9
  eret_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handlerActive && eretPulse) |=> (redirectValid && flushFront && !flushEx));

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] FIXED_ENTRY = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE    = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE  = 32'h0000_0020,
  parameter logic [PC_W-1:0] INSN_BYTES  = 32'h0000_0004
) (
  input  logic            clk,
  input  logic            rstN,
  input  excStrobeT       strobe,
  input  logic [PC_W-1:0] exPc,
  input  logic            vecMode,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] epcOut,
  output causeE           causeOut
);

  localparam int CODE_W = $bits(causeE);

  logic [PC_W-1:0] epcNext;
  logic [PC_W-1:0] vecTarget;
  logic [PC_W-1:0] entryPc;

  // synchronous faults resume after the instruction, interrupts restart it
  assign epcNext   = strobe.syncFault ? (exPc + INSN_BYTES) : exPc;
  assign vecTarget = VEC_BASE + ({{(PC_W-CODE_W){1'b0}}, strobe.code} * VEC_STRIDE);
  assign entryPc   = vecMode ? vecTarget : FIXED_ENTRY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcOut     <= '0;
      causeOut   <= CAUSE_UNDEF;
      redirectPc <= '0;
    end else if (strobe.capture) begin
      epcOut     <= epcNext;
      causeOut   <= strobe.code;
      redirectPc <= entryPc;
    end else if (strobe.eretTake) begin
      redirectPc <= epcOut;
    end
  end

  // R2
  epc_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.syncFault) |=> epcOut == $past(exPc) + INSN_BYTES);

  // R5
  fixed_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !vecMode) |=> redirectPc == FIXED_ENTRY);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture) |=> ($stable(epcOut) && $stable(causeOut)));

endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            exUndef,
  input  logic            exOvf,
  input  logic [PC_W-1:0] exPc,
  input  logic            irqReq,
  input  logic            vecMode,
  input  logic            eretPulse,
  output logic            flushFront,
  output logic            flushEx,
  output logic            wbSuppress,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] epcOut,
  output logic [1:0]      causeOut
);

  excStrobeT strobe;
  causeE     causeQ;

  exc_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .exUndef      (exUndef),
    .exOvf        (exOvf),
    .irqReq       (irqReq),
    .eretPulse    (eretPulse),
    .strobe       (strobe),
    .flushFront   (flushFront),
    .flushEx      (flushEx),
    .wbSuppress   (wbSuppress),
    .redirectValid(redirectValid)
  );

  exc_datapath #(.PC_W(PC_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .exPc      (exPc),
    .vecMode   (vecMode),
    .redirectPc(redirectPc),
    .epcOut    (epcOut),
    .causeOut  (causeQ)
  );

  assign causeOut = causeQ;

  // R4
  undef_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushEx && wbSuppress && $past(exUndef)) |-> causeOut == 2'b00);

endmodule

// File: tb/tb_exc_unit.sv
`timescale 1ns/1ps
module tb_exc_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        exUndef, exOvf, irqReq, vecMode, eretPulse;
  logic [31:0] exPc;
  logic        flushFront, flushEx, wbSuppress, redirectValid;
  logic [31:0] redirectPc, epcOut;
  logic [1:0]  causeOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model state
  bit          mActive;
  logic [31:0] mEpc;
  logic [1:0]  mCause;
  bit          eFront, eEx, eWb, eRv;
  logic [31:0] eTarget;

  always #2 clk = ~clk;

  exc_unit dut (
    .clk(clk), .rstN(rstN), .exUndef(exUndef), .exOvf(exOvf), .exPc(exPc),
    .irqReq(irqReq), .vecMode(vecMode), .eretPulse(eretPulse),
    .flushFront(flushFront), .flushEx(flushEx), .wbSuppress(wbSuppress),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .epcOut(epcOut), .causeOut(causeOut)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "flushFront", {31'b0, flushFront}, {31'b0, eFront});
    chk(tag, "flushEx", {31'b0, flushEx}, {31'b0, eEx});
    chk(tag, "wbSuppress", {31'b0, wbSuppress}, {31'b0, eWb});
    chk(tag, "redirectValid", {31'b0, redirectValid}, {31'b0, eRv});
    if (eRv) chk(tag, "redirectPc", redirectPc, eTarget);
    chk(tag, "epcOut", epcOut, mEpc);
    chk(tag, "causeOut", {30'b0, causeOut}, {30'b0, mCause});
  endtask

  // one clock: drive at negedge, model at posedge, compare after the edge
  task automatic step(input bit u, input bit o, input bit i, input bit r,
                      input bit v, input logic [31:0] pc, input string tag);
    @(negedge clk);
    exUndef = u; exOvf = o; irqReq = i; eretPulse = r; vecMode = v; exPc = pc;
    @(posedge clk);
    eFront = 0; eEx = 0; eWb = 0; eRv = 0;
    if (!mActive && (u || o || i)) begin
      mCause  = u ? 2'd0 : (o ? 2'd1 : 2'd2);
      mEpc    = (u || o) ? pc + 32'd4 : pc;
      eTarget = v ? (32'hC000_0000 + 32'h20 * mCause) : 32'h8000_0180;
      eFront = 1; eEx = 1; eRv = 1; eWb = u || o;
      mActive = 1;
    end else if (mActive && r) begin
      eTarget = mEpc;
      eFront = 1; eRv = 1;
      mActive = 0;
    end
    #1;
    compareAll(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 0; exUndef = 0; exOvf = 0; irqReq = 0; eretPulse = 0; vecMode = 0; exPc = '0;
    mActive = 0; mEpc = '0; mCause = '0; eTarget = '0;
    eFront = 0; eEx = 0; eWb = 0; eRv = 0;
    repeat (3) @(posedge clk);
    #1 compareAll("R1 in reset");
    @(negedge clk) rstN = 1;
    step(0,0,0,0,0, 32'h0, "R1 idle");

    // fixed-mode undefined opcode, then masking, then return
    step(1,0,0,0,0, 32'h0000_0040, "R2 R5 undef");
    step(0,0,0,0,0, 32'h0000_0044, "R11 pulse ends");
    step(0,1,1,0,0, 32'h0000_0048, "R8 masked ovf+irq");
    step(1,0,0,0,1, 32'h0000_004C, "R8 masked undef");
    step(0,0,0,1,0, 32'h0000_0100, "R9 return");
    step(0,0,0,0,0, 32'h0000_0044, "R9 after return");

    // vectored overflow
    step(0,1,0,0,1, 32'h0000_004C, "R3 R6 ovf vectored");
    step(0,0,0,0,1, 32'h0, "R11 idle");
    step(0,1,0,1,1, 32'h0000_0200, "R8 return with ovf");
    step(0,1,0,0,1, 32'h0000_0300, "R9 rearmed ovf");
    step(0,0,0,1,1, 32'h0, "R9 return 2");

    // both flags
    step(1,1,0,0,1, 32'h0000_0500, "R4 both flags");
    step(0,0,0,1,1, 32'h0, "R9 return 3");

    // interrupt vectored
    step(0,0,1,0,1, 32'h0000_0600, "R7 R6 irq vectored");
    step(0,0,1,0,1, 32'h0000_0604, "R8 irq held");
    step(0,0,0,1,1, 32'h0, "R7 R9 return to irq pc");

    // interrupt together with overflow
    step(0,1,1,0,1, 32'h0000_0700, "R7 ovf beats irq");
    step(0,0,0,1,0, 32'h0, "R9 return 4");

    // return while idle
    step(0,0,0,1,0, 32'h0000_0800, "R10 stray return");
    step(0,0,0,1,1, 32'h0000_0804, "R10 stray return 2");

    // interrupt in fixed mode
    step(0,0,1,0,0, 32'h0000_0900, "R5 R7 irq fixed");
    step(0,0,0,0,0, 32'h0, "R11 irq pulse ends");
    step(0,0,0,1,0, 32'h0, "R9 return 5");
    // overflow right after return
    step(0,1,0,0,0, 32'h0000_0A00, "R3 R5 ovf fixed");
    step(0,0,0,0,0, 32'h0, "R11 ovf pulse ends");
    step(0,0,0,1,0, 32'h0, "R9 return 6");
    step(0,0,0,0,0, 32'h0, "R1 quiet");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule